// File: doc/BRIEF.md
# Password Check with Retry Lockout

This block guards a protected memory with two 64-bit keys: a read key and a write key. A host streams a candidate key one byte per accepted transfer, then pulses `frame_end` together with `pw_sel`, which names the key to test. Every check, right or wrong, starts a self-timed wait that stands in for a slow nonvolatile write. While the wait runs the block reports busy and never shows a grant. When the wait ends, `access_ok` rises only if the candidate matched.

Wrong attempts add up in a failure counter. Any mix of read-key and write-key failures counts toward it. A correct key clears the counter. The failure that brings the counter to `MAX_FAILS` arms a wipe. After the wait, the block raises `erase_req` to the memory and keeps `busy` high until `erase_done` comes back. Both keys then become all zeros and the counter returns to zero.

A host that holds a grant on the write key may load a new value into either key. The load costs one timed wait. No port ever reads a stored key out.

The byte input is a valid/ready stream. `in_ready` is low for the whole wait and erase. It is also low in any cycle where `frame_end` is high. A byte is taken only in a cycle where `in_valid` and `in_ready` are both high. A host that sees `in_ready` low holds its byte until a later cycle.

Top module: `pwg_guard`

## Requirements
- R1: After reset `busy`, `access_ok` and `erase_req` are low, `in_ready` is high, and both keys are all zeros.
- R2: The k-th byte accepted in a frame (k starting at 0) is compared with bits [8k+7:8k] of the selected key. `pw_sel`=0 selects the read key and `pw_sel`=1 selects the write key. `pw_sel` is sampled in the `frame_end` cycle.
- R3: A check passes only if exactly `PW_BYTES` bytes were accepted and every one of them matched. A frame with fewer or more bytes is a failed attempt.
- R4: A `frame_end` seen while not busy starts a wait in which `busy` is high for exactly `BUSY_CYCLES` cycles. During the wait `in_ready` is low, and `frame_end` or `in_valid` has no effect.
- R5: `access_ok` is low during every wait. After the wait, `access_ok` is high only if the last check passed, and it stays high until the next check.
- R6: A passing check clears the failure count, so `MAX_FAILS-1` failures, a pass, and `MAX_FAILS-1` further failures cause no erase.
- R7: The failure that makes `MAX_FAILS` cumulative failures holds `busy` high past its wait. `erase_req` stays high until `erase_done` is seen, and `erase_req` is high only while busy.
- R8: When the erase finishes, both keys are all zeros and the failure count is zero.
- R9: `pw_load` writes `pw_load_data` into the key chosen by `pw_load_sel` (0 read, 1 write) and starts a `BUSY_CYCLES` wait. This happens only when `access_ok` is high from a write-key check. In any other case `pw_load` is ignored and starts no wait.
- R10: In a cycle with `frame_end` high, `in_ready` is low, so a byte offered in that cycle is not part of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Candidate byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Candidate byte |
| pw_sel | input | 1 | Key under test: 0 read, 1 write |
| frame_end | input | 1 | Pulse that closes the frame and starts the check |
| pw_load | input | 1 | Request to replace a key |
| pw_load_sel | input | 1 | Key to replace: 0 read, 1 write |
| pw_load_data | input | 64 | New key value |
| busy | output | 1 | Timed wait or erase in progress |
| access_ok | output | 1 | Last check passed and no wait is running |
| erase_req | output | 1 | Request to clear the protected memory |
| erase_done | input | 1 | Memory reports that the clear is complete |

## Verification
Some rules can be checked on every cycle, and the checker does so. The stream must stall for the whole wait. A check must be followed at once by busy with no grant. The erase request must stay under busy, be held until acknowledged, and drop only after `erase_done`. The failure count must stay below its limit.

Other behaviour shows only over whole scenarios, and the directed tests cover it. These tests confirm the exact wait length and the byte order against a stored key. They check that short and long frames are refused and that a pass resets the count. They show that the wipe starts on the right failure and that both keys really return to zeros. They also confirm that key loads without a write grant are ignored.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_WIPE = 2'd2
  } pwg_state_t;

  localparam int BYTE_W = 8;
  localparam int NUM_KEYS = 2;
endpackage

// File: rtl/pwg_cmp.sv
module pwg_cmp #(
  parameter int NB   = 8,
  parameter int KEYS = 2,
  localparam int CW  = $clog2(NB + 2)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       take,
  input  logic [7:0]                 in_byte,
  input  logic [KEYS-1:0][NB*8-1:0]  keys,
  output logic [CW-1:0]              cnt,
  output logic [KEYS-1:0]            miss
);
  // byte counter saturates one past a full key, marking an overlong frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (clr)                      cnt <= '0;
    else if (take && cnt <= CW'(NB))   cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < KEYS; g++) begin : g_key
    logic [7:0] cur;
    always_comb begin
      cur = '0;
      for (int b = 0; b < NB; b++)
        if (cnt == CW'(b)) cur = keys[g][8*b +: 8];
    end
    // sticky mismatch against this key
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          miss[g] <= 1'b0;
      else if (clr)                                        miss[g] <= 1'b0;
      else if (take && cnt < CW'(NB) && in_byte != cur)    miss[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/pwg_timer.sv
module pwg_timer #(
  parameter int CYC = 16,
  localparam int TW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic last
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= TW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == TW'(1));
endmodule

// File: rtl/pwg_retry.sv
module pwg_retry #(
  parameter int MAX = 8,
  localparam int RW = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic          hit,
  output logic [RW-1:0] cnt
);
  assign hit = inc && (cnt == RW'(MAX - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (clr)                       cnt <= '0;
    else if (inc && !hit)               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwg_guard.sv
module pwg_guard
  import pwg_pkg::*;
#(
  parameter int PW_BYTES    = 8,
  parameter int BUSY_CYCLES = 16,
  parameter int MAX_FAILS   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_data,
  input  logic                    pw_sel,
  input  logic                    frame_end,
  input  logic                    pw_load,
  input  logic                    pw_load_sel,
  input  logic [PW_BYTES*8-1:0]   pw_load_data,
  output logic                    busy,
  output logic                    access_ok,
  output logic                    erase_req,
  input  logic                    erase_done
);
  localparam int PW_W = PW_BYTES * BYTE_W;
  localparam int CW   = $clog2(PW_BYTES + 2);
  localparam int RW   = $clog2(MAX_FAILS + 1);

  pwg_state_t                    state;
  logic [NUM_KEYS-1:0][PW_W-1:0] key_q;
  logic [CW-1:0]                 byte_cnt;
  logic [NUM_KEYS-1:0]           miss;
  logic                          granted_q, grant_wr_q, wipe_pend;
  logic                          idle, chk_go, load_go, verdict, tmr_last;
  logic                          fail_hit, wipe_fin;
  logic [RW-1:0]                 fail_cnt;

  assign idle     = (state == ST_IDLE);
  assign chk_go   = idle && frame_end;
  assign load_go  = idle && !frame_end && pw_load && granted_q && grant_wr_q;
  assign verdict  = (byte_cnt == CW'(PW_BYTES)) && !miss[pw_sel];
  assign wipe_fin = (state == ST_WIPE) && erase_done;

  assign in_ready  = idle && !frame_end;
  assign busy      = !idle;
  assign access_ok = idle && granted_q;
  assign erase_req = (state == ST_WIPE);

  pwg_cmp #(.NB(PW_BYTES), .KEYS(NUM_KEYS)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (chk_go || load_go),
    .take    (in_valid && in_ready),
    .in_byte (in_data),
    .keys    (key_q),
    .cnt     (byte_cnt),
    .miss    (miss)
  );

  pwg_timer #(.CYC(BUSY_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (chk_go || load_go),
    .last  (tmr_last)
  );

  pwg_retry #(.MAX(MAX_FAILS)) u_retry (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   ((chk_go && verdict) || wipe_fin),
    .inc   (chk_go && !verdict),
    .hit   (fail_hit),
    .cnt   (fail_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      key_q      <= '0;
      granted_q  <= 1'b0;
      grant_wr_q <= 1'b0;
      wipe_pend  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (chk_go) begin
            granted_q  <= verdict;
            grant_wr_q <= pw_sel;
            wipe_pend  <= fail_hit;
            state      <= ST_WAIT;
          end else if (load_go) begin
            key_q[pw_load_sel] <= pw_load_data;
            state              <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tmr_last) state <= wipe_pend ? ST_WIPE : ST_IDLE;
        end
        ST_WIPE: begin
          if (erase_done) begin
            key_q      <= '0;
            granted_q  <= 1'b0;
            grant_wr_q <= 1'b0;
            wipe_pend  <= 1'b0;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwg_guard_chk.sv
module pwg_guard_chk #(
  parameter int MAX_FAILS = 8,
  localparam int RW = $clog2(MAX_FAILS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          in_ready,
  input logic          access_ok,
  input logic          erase_req,
  input logic          erase_done,
  input logic          frame_end,
  input logic [RW-1:0] fail_cnt
);
  AST_STALL_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready); // R4

  AST_CHECK_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !busy) |=> (busy && !access_ok)); // R5

  AST_ERASE_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> busy); // R7

  AST_ERASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && !erase_done) |=> erase_req); // R7

  AST_ERASE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_req) |-> $past(erase_done)); // R8

  AST_FAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fail_cnt < RW'(MAX_FAILS)); // R6
endmodule

bind pwg_guard pwg_guard_chk #(.MAX_FAILS(MAX_FAILS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .in_ready   (in_ready),
  .access_ok  (access_ok),
  .erase_req  (erase_req),
  .erase_done (erase_done),
  .frame_end  (frame_end),
  .fail_cnt   (fail_cnt)
);

// File: tb/pwg_guard_tb.sv
module pwg_guard_tb;
  localparam int BUSY = 16;
  localparam int MAXF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, frame_end = 1'b0, pw_sel = 1'b0;
  logic [7:0]  in_data = '0;
  logic        pw_load = 1'b0, pw_load_sel = 1'b0;
  logic [63:0] pw_load_data = '0;
  logic        erase_done = 1'b0;
  logic        in_ready, busy, access_ok, erase_req;

  int total = 0, bad = 0, erase_hits = 0;

  localparam logic [63:0] KEY_W = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] KEY_R = 64'h1122_3344_5566_7788;

  always #2.5 clk = ~clk;

  pwg_guard #(.PW_BYTES(8), .BUSY_CYCLES(BUSY), .MAX_FAILS(MAXF)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pw_sel(pw_sel), .frame_end(frame_end),
    .pw_load(pw_load), .pw_load_sel(pw_load_sel), .pw_load_data(pw_load_data),
    .busy(busy), .access_ok(access_ok), .erase_req(erase_req),
    .erase_done(erase_done)
  );

  // memory model answering erase requests after a short delay
  initial begin
    forever begin
      @(negedge clk);
      if (erase_req) begin
        erase_hits++;
        repeat (3) @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bytes(input logic [63:0] v, input int n);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1;
      in_data  = (k < 8) ? v[8*k +: 8] : 8'hA5;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // close frame, count busy cycles, return the grant seen afterwards
  task automatic close_frame(input logic sel, output int len, output logic ok);
    frame_end = 1'b1;
    pw_sel    = sel;
    @(negedge clk);
    frame_end = 1'b0;
    len = 0;
    while (busy && len < 5000) begin
      len++;
      if (access_ok !== 1'b0 || in_ready !== 1'b0) begin
        total++; bad++;
        $display("FAIL R5: actual ok=%0b rdy=%0b expected 0 0 while busy", access_ok, in_ready);
      end
      @(negedge clk);
    end
    ok = access_ok;
  endtask

  task automatic attempt(input logic [63:0] v, input int n, input logic sel,
                         output int len, output logic ok);
    send_bytes(v, n);
    close_frame(sel, len, ok);
  endtask

  task automatic load_key(input logic sel, input logic [63:0] v, output int len);
    pw_load = 1'b1; pw_load_sel = sel; pw_load_data = v;
    @(negedge clk);
    pw_load = 1'b0;
    len = 0;
    while (busy && len < 5000) begin len++; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 access_ok", access_ok, 0);
    chk("R1 erase_req", erase_req, 0);
    chk("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_zero_keys();
    int len; logic ok;
    attempt(64'h0, 8, 1'b0, len, ok);
    chk("R4 wait length", len, BUSY);
    chk("R1 zero read key grants", ok, 1);
    attempt(64'h0, 8, 1'b1, len, ok);
    chk("R1 zero write key grants", ok, 1);
  endtask

  task automatic t_load();
    int len; logic ok;
    attempt(64'h0, 8, 1'b0, len, ok);       // read grant only
    load_key(1'b1, KEY_W, len);
    chk("R9 load ignored without write grant", len, 0);
    attempt(64'h0, 8, 1'b1, len, ok);
    chk("R9 write key unchanged after ignored load", ok, 1);
    load_key(1'b1, KEY_W, len);
    chk("R9 load wait length", len, BUSY);
    load_key(1'b0, KEY_R, len);
    chk("R9 second load accepted", len, BUSY);
    attempt(KEY_R, 8, 1'b0, len, ok);
    chk("R2 read key match", ok, 1);
    attempt(KEY_R, 8, 1'b1, len, ok);
    chk("R2 read key against write select", ok, 0);
    chk("R5 deny still costs full wait", len, BUSY);
    attempt({KEY_W[7:0], KEY_W[15:8], KEY_W[23:16], KEY_W[31:24],
             KEY_W[39:32], KEY_W[47:40], KEY_W[55:48], KEY_W[63:56]}, 8, 1'b1, len, ok);
    chk("R2 reversed byte order refused", ok, 0);
    attempt(KEY_W, 7, 1'b1, len, ok);
    chk("R3 short frame refused", ok, 0);
    attempt(KEY_W, 9, 1'b1, len, ok);
    chk("R3 long frame refused", ok, 0);
    attempt(KEY_W, 8, 1'b1, len, ok);
    chk("R3 exact frame grants", ok, 1);
  endtask

  task automatic t_busy_ignore();
    int len; logic ok;
    send_bytes(KEY_W, 8);
    frame_end = 1'b1; pw_sel = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    repeat (3) @(negedge clk);
    in_valid = 1'b1; in_data = 8'h00; frame_end = 1'b1;
    #1;
    chk("R4 in_ready low while busy", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0; frame_end = 1'b0;
    len = 4;
    while (busy && len < 5000) begin len++; @(negedge clk); end
    chk("R4 frame_end during wait ignored", len, BUSY);
    chk("R5 grant after wait", access_ok, 1);
    attempt(KEY_W, 8, 1'b1, len, ok);
    chk("R4 input during wait did not enter frame", ok, 1);
  endtask

  task automatic t_same_cycle();
    int len; logic ok;
    send_bytes(KEY_W, 8);
    in_valid = 1'b1; in_data = 8'hFF; frame_end = 1'b1; pw_sel = 1'b1;
    #1;
    chk("R10 in_ready low with frame_end", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0; frame_end = 1'b0;
    len = 0;
    while (busy && len < 5000) begin len++; @(negedge clk); end
    chk("R10 byte with frame_end not counted", access_ok, 1);
  endtask

  task automatic t_retry_reset();
    int len; logic ok; int e0;
    e0 = erase_hits;
    for (int i = 0; i < MAXF - 1; i++) attempt(64'h0, 8, 1'b1, len, ok);
    attempt(KEY_W, 8, 1'b1, len, ok);
    chk("R6 pass after near limit", ok, 1);
    for (int i = 0; i < MAXF - 1; i++) attempt(64'h0, 8, 1'b0, len, ok);
    chk("R6 no erase after count reset", erase_hits - e0, 0);
    attempt(KEY_W, 8, 1'b1, len, ok);
  endtask

  task automatic t_wipe();
    int len; logic ok; int e0;
    e0 = erase_hits;
    for (int i = 0; i < MAXF - 1; i++) attempt(64'h0, 8, 1'b0, len, ok);
    chk("R7 no erase before limit", erase_hits - e0, 0);
    attempt(64'h0, 8, 1'b1, len, ok);
    chk("R7 erase on limit failure", erase_hits - e0, 1);
    chk("R7 busy held past wait", len > BUSY, 1);
    chk("R7 erase_req released", erase_req, 0);
    attempt(64'h0, 8, 1'b0, len, ok);
    chk("R8 read key zero after wipe", ok, 1);
    attempt(64'h0, 8, 1'b1, len, ok);
    chk("R8 write key zero after wipe", ok, 1);
    e0 = erase_hits;
    attempt(KEY_W, 8, 1'b1, len, ok);
    chk("R8 old write key refused", ok, 0);
    for (int i = 0; i < MAXF - 2; i++) attempt(KEY_R, 8, 1'b0, len, ok);
    chk("R8 count restarted after wipe", erase_hits - e0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_keys();
    t_load();
    t_busy_ignore();
    t_same_cycle();
    t_retry_reset();
    t_wipe();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule